// File: doc/BRIEF.md
# CAM Slice with Next-Free Cascade and Full Chain

This block is one slice of a content-addressable memory that can be chained with identical slices. It holds 16 entries, each a 16-bit word plus a valid flag, and a comparand (search key) register. Slices are linked through an active-low full chain: each slice takes a full-in from its upstream neighbour and drives a full-out to its downstream neighbour. The first slice has its full-in tied low. A slice drives full-out low once its upstream is full and it is full itself, so the full-out of the last slice reports that the whole string is full.

Every instruction goes to all slices at once, and the chain decides which slice acts. A move-to-free instruction copies the comparand into the lowest-index empty entry and sets that entry valid. Only the slice whose full-in is low and whose own full-out is high carries it out, which is the slice holding the first free location of the whole string. The same gating steps a page-address load through the string during initialization. A set-full instruction loads the page address into the one enabled slice and forces that slice's full-out low, which passes the enable to the next slice. An end-of-init instruction releases the forced state in every slice. A compare searches the valid entries for the comparand and reports whether there is a hit and the lowest matching index.

The controller has two states. ST_RUN is normal operation. ST_HOLD_FULL means a set-full has been taken and full-out is forced. The transition ST_RUN to ST_HOLD_FULL happens on a set-full while the slice is enabled. The transition ST_HOLD_FULL to ST_RUN happens on an end-of-init. Reset returns the controller to ST_RUN.

Top module: `cam_nf_slice`

## Requirements
- R1: After reset no entry is valid, the controller is in ST_RUN, page_addr is 0, the comparand is 0, and match_valid, match_hit and match_idx are 0.
- R2: full_out_n is low exactly when full_in_n is low and either all 16 entries are valid or the slice is in ST_HOLD_FULL. Otherwise full_out_n is high. This output is combinational.
- R3: Command code 2 (move-to-free), issued while full_in_n is low and full_out_n is high, writes the comparand into the lowest-index invalid entry and sets that entry valid at the next clock edge.
- R4: Command code 2 has no effect on any entry while full_in_n is high or full_out_n is low.
- R5: Command code 3 (set-full), issued while full_in_n is low and full_out_n is high, loads cmd_data[PA_W-1:0] into page_addr and enters ST_HOLD_FULL at the next edge. As a result full_out_n goes low.
- R6: Command code 3 issued while the slice is not enabled leaves page_addr and the state unchanged.
- R7: Command code 5 (end-of-init) returns the slice from ST_HOLD_FULL to ST_RUN in every slice, whatever the chain state.
- R8: Command code 4 (compare) makes match_valid high for exactly one cycle after the command edge. In that cycle match_hit tells whether any valid entry equals the comparand, and match_idx gives the lowest such index (0 when there is no hit). match_hit and match_idx hold until the next compare.
- R9: An invalid entry never produces a hit, whatever its stored word.
- R10: Command code 1 (load key) loads cmd_data into the comparand in every slice, regardless of the full chain. Code 0 does nothing. Commands act only when cmd_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one command per cycle |
| cmd_op | input | 3 | Command code: 0 nop, 1 load key, 2 move-to-free, 3 set-full, 4 compare, 5 end-of-init |
| cmd_data | input | 16 | Key for load; page address in the low PA_W bits for set-full |
| full_in_n | input | 1 | Active-low full indication from the upstream slice |
| full_out_n | output | 1 | Active-low full indication to the downstream slice |
| page_addr | output | 8 | Page address register of this slice |
| match_valid | output | 1 | One-cycle pulse after a compare |
| match_hit | output | 1 | Result of the last compare: some valid entry matched |
| match_idx | output | 4 | Lowest matching index of the last compare |

## Verification
The assertions check the following on every cycle:
- a move-to-free write always sets the valid flag of the entry it targets;
- the valid flags do not change in a cycle without a write;
- a set-full either loads the page address and pulls full-out low, or leaves both untouched;
- end-of-init always lands in ST_RUN;
- match_valid pulses only after a compare.

Some properties only the bench scenarios can show:
- which entry a move picks;
- that the stored word equals the comparand, and that a compare finds the lowest of several duplicate words;
- that invalid entries stay silent;
- that a full slice or a forced slice ignores moves.

The bench shows these by comparing against a model, over directed fill, initialization and chain sequences and a seeded random command mix.

// File: rtl/cam_nf_pkg.sv
package cam_nf_pkg;

    typedef enum logic [2:0] {
        OP_NOP       = 3'd0,
        OP_LOAD_KEY  = 3'd1,
        OP_MOVE_FREE = 3'd2,
        OP_SET_FULL  = 3'd3,
        OP_COMPARE   = 3'd4,
        OP_END_INIT  = 3'd5
    } op_e;

    typedef enum logic {
        ST_RUN       = 1'b0,
        ST_HOLD_FULL = 1'b1
    } ctrl_st_e;

endpackage

// File: rtl/cam_nf_prio.sv
module cam_nf_prio #(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);

    // Lowest set bit wins: scan downward so the last assignment is the lowest index.
    always_comb begin
        found = |req;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end

endmodule

// File: rtl/cam_nf_array.sv
module cam_nf_array #(
    parameter int N  = 16,
    parameter int DW = 16,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] key,
    output logic [N-1:0]  hit_vec,
    output logic [N-1:0]  free_vec,
    output logic          all_valid
);

    logic [DW-1:0] mem_q [N];
    logic [N-1:0]  valid_q;

    always_ff @(posedge clk) begin
        if (we) mem_q[widx] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  valid_q       <= '0;
        else if (we) valid_q[widx] <= 1'b1;
    end

    for (genvar g = 0; g < N; g++) begin : g_cell
        assign hit_vec[g]  = valid_q[g] && (mem_q[g] == key);
        assign free_vec[g] = ~valid_q[g];
    end

    assign all_valid = &valid_q;

    AST_MOVE_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> valid_q[$past(widx)]);  // R3

    AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(valid_q));  // R4

endmodule

// File: rtl/cam_nf_ctrl.sv
module cam_nf_ctrl
    import cam_nf_pkg::*;
#(
    parameter int N    = 16,
    parameter int DW   = 16,
    parameter int PA_W = 8,
    parameter int IW   = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic [2:0]      cmd_op,
    input  logic [DW-1:0]   cmd_data,
    input  logic            full_in_n,
    input  logic            all_valid,
    input  logic            free_found,
    input  logic [IW-1:0]   free_idx,
    input  logic            hit_found,
    input  logic [IW-1:0]   hit_idx,
    output logic            wr_en,
    output logic [IW-1:0]   wr_idx,
    output logic [DW-1:0]   key,
    output logic            forced,
    output logic [PA_W-1:0] page_addr,
    output logic            match_valid,
    output logic            match_hit,
    output logic [IW-1:0]   match_idx
);

    ctrl_st_e state_q, state_d;
    op_e      op;
    logic     enabled;
    logic     is_move, is_sff, is_end, is_cmp, is_load;

    assign op      = op_e'(cmd_op);
    assign is_load = cmd_valid && (op == OP_LOAD_KEY);
    assign is_move = cmd_valid && (op == OP_MOVE_FREE);
    assign is_sff  = cmd_valid && (op == OP_SET_FULL);
    assign is_cmp  = cmd_valid && (op == OP_COMPARE);
    assign is_end  = cmd_valid && (op == OP_END_INIT);

    // The slice holding the string's first free location: upstream full, itself not full.
    assign enabled = !full_in_n && free_found && !all_valid && (state_q == ST_RUN);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:       if (is_sff && enabled) state_d = ST_HOLD_FULL;
            ST_HOLD_FULL: if (is_end)            state_d = ST_RUN;
            default:                             state_d = ST_RUN;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        forced = 1'b0;
        wr_en  = 1'b0;
        unique case (state_q)
            ST_RUN:       wr_en  = is_move && enabled;
            ST_HOLD_FULL: forced = 1'b1;
            default:      forced = 1'b0;
        endcase
    end
    assign wr_idx = free_idx;

    // Data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key         <= '0;
            page_addr   <= '0;
            match_valid <= 1'b0;
            match_hit   <= 1'b0;
            match_idx   <= '0;
        end else begin
            match_valid <= is_cmp;
            if (is_load) key <= cmd_data;
            if (is_sff && enabled) page_addr <= cmd_data[PA_W-1:0];
            if (is_cmp) begin
                match_hit <= hit_found;
                match_idx <= hit_found ? hit_idx : '0;
            end
        end
    end

    AST_SFF_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (is_sff && enabled) |=> (page_addr == $past(cmd_data[PA_W-1:0])) && (state_q == ST_HOLD_FULL));  // R5

    AST_SFF_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (is_sff && !enabled) |=> $stable(page_addr));  // R6

    AST_END_INIT_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        is_end |=> (state_q == ST_RUN));  // R7

    AST_MATCH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !is_cmp |=> !match_valid);  // R8

    AST_MATCH_AFTER_CMP: assert property (@(posedge clk) disable iff (!rst_n)
        is_cmp |=> match_valid);  // R8

endmodule

// File: rtl/cam_nf_slice.sv
module cam_nf_slice #(
    parameter int N    = 16,
    parameter int DW   = 16,
    parameter int PA_W = 8,
    parameter int IW   = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic [2:0]      cmd_op,
    input  logic [DW-1:0]   cmd_data,
    input  logic            full_in_n,
    output logic            full_out_n,
    output logic [PA_W-1:0] page_addr,
    output logic            match_valid,
    output logic            match_hit,
    output logic [IW-1:0]   match_idx
);

    logic [N-1:0]  hit_vec, free_vec;
    logic          all_valid, free_found, hit_found, wr_en, forced;
    logic [IW-1:0] free_idx, hit_idx, wr_idx;
    logic [DW-1:0] key;

    cam_nf_array #(.N(N), .DW(DW), .IW(IW)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (wr_en),
        .widx      (wr_idx),
        .wdata     (key),
        .key       (key),
        .hit_vec   (hit_vec),
        .free_vec  (free_vec),
        .all_valid (all_valid)
    );

    cam_nf_prio #(.N(N), .IW(IW)) u_free_enc (
        .req   (free_vec),
        .found (free_found),
        .idx   (free_idx)
    );

    cam_nf_prio #(.N(N), .IW(IW)) u_hit_enc (
        .req   (hit_vec),
        .found (hit_found),
        .idx   (hit_idx)
    );

    cam_nf_ctrl #(.N(N), .DW(DW), .PA_W(PA_W), .IW(IW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_op      (cmd_op),
        .cmd_data    (cmd_data),
        .full_in_n   (full_in_n),
        .all_valid   (all_valid),
        .free_found  (free_found),
        .free_idx    (free_idx),
        .hit_found   (hit_found),
        .hit_idx     (hit_idx),
        .wr_en       (wr_en),
        .wr_idx      (wr_idx),
        .key         (key),
        .forced      (forced),
        .page_addr   (page_addr),
        .match_valid (match_valid),
        .match_hit   (match_hit),
        .match_idx   (match_idx)
    );

    assign full_out_n = full_in_n | ~(all_valid | forced);

    AST_SFF_BLOCKS_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd3 && !full_in_n && full_out_n) |=> (full_in_n || !full_out_n));  // R5

endmodule

// File: tb/cam_nf_slice_tb_top.sv
module cam_nf_slice_tb_top;
    import cam_nf_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int N    = 16;
    localparam int DW   = 16;
    localparam int PA_W = 8;
    localparam int IW   = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cmd_valid = 1'b0;
    logic [2:0]      cmd_op = 3'd0;
    logic [DW-1:0]   cmd_data = '0;
    logic            full_in_n = 1'b0;
    logic            full_out_n;
    logic [PA_W-1:0] page_addr;
    logic            match_valid, match_hit;
    logic [IW-1:0]   match_idx;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model
    bit            m_valid [N];
    logic [DW-1:0] m_data  [N];
    logic [DW-1:0] m_key;
    logic [PA_W-1:0] m_pa;
    bit            m_forced;

    always #(CLK_PERIOD/2) clk = ~clk;

    cam_nf_slice #(.N(N), .DW(DW), .PA_W(PA_W), .IW(IW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .full_in_n(full_in_n), .full_out_n(full_out_n),
        .page_addr(page_addr), .match_valid(match_valid), .match_hit(match_hit),
        .match_idx(match_idx)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit m_all_valid();
        for (int i = 0; i < N; i++) if (!m_valid[i]) return 1'b0;
        return 1'b1;
    endfunction

    function automatic int m_first_free();
        for (int i = 0; i < N; i++) if (!m_valid[i]) return i;
        return -1;
    endfunction

    function automatic int m_lookup(input logic [DW-1:0] k);
        for (int i = 0; i < N; i++) if (m_valid[i] && m_data[i] == k) return i;
        return -1;
    endfunction

    function automatic bit m_full_out(input bit fin);
        return fin | ~(m_all_valid() | m_forced);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cmd_valid = 1'b0;
        cmd_op = 3'd0;
        full_in_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < N; i++) begin
            m_valid[i] = 1'b0;
            m_data[i] = '0;
        end
        m_key = '0;
        m_pa = '0;
        m_forced = 1'b0;
    endtask

    // One command: drive at a falling edge, observe at the next falling edge.
    task automatic do_op(input logic [2:0] o, input logic [DW-1:0] d, input bit fin);
        bit en;
        int hit_at;
        hit_at = -1;
        @(negedge clk);
        full_in_n = fin;
        cmd_valid = 1'b1;
        cmd_op = o;
        cmd_data = d;
        en = !fin && !m_all_valid() && !m_forced;
        if (o == 3'd4) hit_at = m_lookup(m_key);
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_op = 3'd0;
        unique case (o)
            3'd1: m_key = d;                                                   // R10
            3'd2: if (en) begin                                                // R3, R4
                      m_data[m_first_free()] = m_key;
                      m_valid[m_first_free()] = 1'b1;
                  end
            3'd3: if (en) begin m_pa = d[PA_W-1:0]; m_forced = 1'b1; end       // R5, R6
            3'd5: m_forced = 1'b0;                                             // R7
            default: ;
        endcase
        chk(full_out_n == m_full_out(fin), "R2 full_out_n", int'(full_out_n), int'(m_full_out(fin)));
        chk(page_addr == m_pa, "R5/R6 page_addr", int'(page_addr), int'(m_pa));
        if (o == 3'd4) begin
            chk(match_valid == 1'b1, "R8 match_valid pulse", int'(match_valid), 1);
            chk(match_hit == (hit_at >= 0), "R8 R9 match_hit", int'(match_hit), int'(hit_at >= 0));
            chk(int'(match_idx) == ((hit_at >= 0) ? hit_at : 0), "R8 match_idx",
                int'(match_idx), (hit_at >= 0) ? hit_at : 0);
        end else begin
            chk(match_valid == 1'b0, "R8 no pulse without compare", int'(match_valid), 0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20250511));
        do_reset();

        // R1: reset state
        @(negedge clk);
        chk(full_out_n == 1'b1, "R1 full_out_n after reset", int'(full_out_n), 1);
        chk(page_addr == '0, "R1 page_addr after reset", int'(page_addr), 0);
        chk(match_valid == 1'b0 && match_hit == 1'b0 && match_idx == '0, "R1 match regs",
            int'({match_valid, match_hit, match_idx}), 0);

        // R9: empty array never hits, even with key 0
        do_op(3'd4, 16'h0000, 1'b0);

        // R6: set-full with upstream not full is ignored
        do_op(3'd3, 16'h00A7, 1'b1);
        // R5: set-full while enabled loads and forces full
        do_op(3'd3, 16'h005A, 1'b0);
        chk(full_out_n == 1'b0, "R5 forced full_out_n", int'(full_out_n), 0);
        // R6: second set-full while forced is ignored
        do_op(3'd3, 16'h00C3, 1'b0);
        // R10: key load works while forced; R4: move while forced does nothing
        do_op(3'd1, 16'h1234, 1'b0);
        do_op(3'd2, 16'h0000, 1'b0);
        do_op(3'd4, 16'h0000, 1'b0);
        chk(match_hit == 1'b0, "R4 move ignored while forced", int'(match_hit), 0);
        // R7: end-of-init releases
        do_op(3'd5, 16'h0000, 1'b0);
        chk(full_out_n == 1'b1, "R7 released full_out_n", int'(full_out_n), 1);

        // R4: move with upstream not full is ignored
        do_op(3'd2, 16'h0000, 1'b1);
        do_op(3'd4, 16'h0000, 1'b0);
        chk(match_hit == 1'b0, "R4 move ignored with full_in_n high", int'(match_hit), 0);

        // R3: fill all entries with distinct words
        for (int i = 0; i < N; i++) begin
            do_op(3'd1, 16'h0100 + 16'(i), 1'b0);
            do_op(3'd2, 16'h0000, 1'b0);
        end
        chk(full_out_n == 1'b0, "R2 all valid drives full", int'(full_out_n), 0);
        for (int i = 0; i < N; i += 5) begin
            do_op(3'd1, 16'h0100 + 16'(i), 1'b0);
            do_op(3'd4, 16'h0000, 1'b0);
            chk(int'(match_idx) == i, "R3 word placed in order", int'(match_idx), i);
        end
        // R4: move into a full slice does nothing
        do_op(3'd1, 16'hBEEF, 1'b0);
        do_op(3'd2, 16'h0000, 1'b0);
        do_op(3'd4, 16'h0000, 1'b0);
        chk(match_hit == 1'b0, "R4 move ignored when full", int'(match_hit), 0);
        // R2: full slice with upstream not full passes high
        do_op(3'd0, 16'h0000, 1'b1);
        chk(full_out_n == 1'b1, "R2 upstream not full", int'(full_out_n), 1);

        // Random mix against the model
        do_reset();
        for (int n = 0; n < 600; n++) begin
            int r;
            logic [2:0] o;
            r = int'($urandom % 20);
            if (r < 6)       o = 3'd1;
            else if (r < 11) o = 3'd2;
            else if (r < 16) o = 3'd4;
            else if (r < 18) o = 3'd3;
            else if (r < 19) o = 3'd5;
            else             o = 3'd0;
            if (m_all_valid() && ($urandom % 6 == 0)) do_reset();
            do_op(o, 16'($urandom % 6) | 16'h0040, ($urandom % 5) == 0);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule